// File: doc/BRIEF.md
# Port-group-mask forwarding resolver

This block turns a lookup result into the set of egress ports for one frame in a small Ethernet switch. It holds a table of port bitmasks. Each lookup reads two entries. One is the destination entry: on a MAC-table hit it is chosen by the hit's destination index, and on a miss by a flood index picked per frame class. The other is the source entry of the ingress port. The forwarded set is the AND of the two. The ingress port is always removed from that set.

The CPU port gets special treatment. A MAC-table hit of entry type 0 or 1 that points at a destination entry with the CPU bit set sends a copy to the CPU even when the source entry would block it. The CPU queue number is taken from that destination entry. Flooded frames never get this exception. A dedicated whitelist entry holds only the CPU bit from reset, so software can steer chosen addresses to the CPU by pointing their MAC-table entries at it. The table is configured through a simple register-style write and read port. The resolver accepts one request per cycle and answers two cycles later.

Top module: `pgm_resolver`

## Requirements
- R1: For a valid request the response mask is the bitwise AND of the destination entry and the source entry of the ingress port, which is stored at index 80 + port. Mask bit j is front-panel port j (0 to 11) and bit 12 is the CPU. The ingress port's own bit is always cleared in the response.
- R2: On a hit (req_hit = 1) the destination entry index is req_dest_idx. On a miss it is flood_uc_idx for class 0, flood_mc_idx for class 1, and flood_bc_idx for class 2 or 3.
- R3: On a hit with entry type 0 or 1 whose destination entry has the CPU bit set, rsp_cpu_copy is 1 and rsp_mask has the CPU bit set, whatever the source entry holds. Entry types 2 and 3 never copy.
- R4: On a miss rsp_cpu_copy is 0. The CPU bit can then appear only through the AND of R1.
- R5: rsp_cpu_queue equals the queue field of the destination entry whenever rsp_mask has the CPU bit set, and is 0 otherwise.
- R6: A request presented in cycle t is answered with rsp_valid = 1 in cycle t + 2. One request may be accepted every cycle. While rsp_valid is 0, rsp_mask, rsp_cpu_copy and rsp_cpu_queue are 0.
- R7: After reset every table entry is zero (mask and queue), except the whitelist entry at index 59, which holds only the CPU bit and queue 0. All outputs are zero during reset.
- R8: A write with cfg_we = 1 stores cfg_wr_mask and cfg_wr_queue at cfg_addr. cfg_rd_mask and cfg_rd_queue show the entry at the cfg_addr of the previous cycle. A read or lookup in the same cycle as a write to the same entry returns the old value.
- R9: The table has indices 0 to 91. Writes to a higher index are ignored, and reads or lookups of a higher index give zero. An ingress port number of 12 or more uses a zero source entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_src_port | input | 4 | Ingress port number |
| req_hit | input | 1 | MAC-table lookup hit |
| req_dest_idx | input | 7 | Destination index from the MAC-table entry |
| req_entry_type | input | 2 | Entry type from the MAC-table entry |
| req_flood_class | input | 2 | Class used on a miss: 0 unicast, 1 multicast, 2 or 3 broadcast |
| flood_uc_idx | input | 7 | Table index flooded for unknown unicast |
| flood_mc_idx | input | 7 | Table index flooded for unknown multicast |
| flood_bc_idx | input | 7 | Table index flooded for broadcast |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 7 | Table index for write and read |
| cfg_wr_mask | input | 13 | Port mask to write |
| cfg_wr_queue | input | 3 | CPU queue field to write |
| cfg_rd_mask | output | 13 | Mask of the entry addressed in the previous cycle |
| cfg_rd_queue | output | 3 | Queue field of the entry addressed in the previous cycle |
| rsp_valid | output | 1 | Response present |
| rsp_mask | output | 13 | Egress port mask |
| rsp_cpu_copy | output | 1 | CPU copy granted by the hit exception |
| rsp_cpu_queue | output | 3 | CPU queue for the frame |

## Verification
The assertions check, on every cycle, the properties that hold whatever the table contains. Valid moves through both stages one cycle at a time. Idle responses are all zero. The ingress bit never appears in the response. A granted copy always carries the CPU bit. A miss never produces a copy. A queue number appears only together with the CPU bit. Only the bench's scenarios can show that the correct entries were chosen and combined. These cover the flood class mapping, the exception overriding a blocking source entry, entry types 2 and 3 being refused, the reset contents of the whitelist entry, the old value returned when a write and a read meet in the same cycle, and out-of-range indices reading as zero.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [1:0] {
    FC_UCAST  = 2'd0,
    FC_MCAST  = 2'd1,
    FC_BCAST  = 2'd2,
    FC_BCAST2 = 2'd3
  } flood_class_e;

  localparam int NUM_RD_PORTS = 3;
  localparam int RD_DEST = 0;
  localparam int RD_SRC  = 1;
  localparam int RD_CFG  = 2;

endpackage

// File: rtl/pgm_table.sv
module pgm_table #(
  parameter int PW      = 13,
  parameter int QW      = 3,
  parameter int IW      = 7,
  parameter int DEPTH   = 92,
  parameter int WL_IDX  = 59,
  parameter int CPU_POS = 12,
  parameter int NRD     = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IW-1:0]            waddr,
  input  logic [PW-1:0]            wmask,
  input  logic [QW-1:0]            wqueue,
  input  logic [NRD-1:0][IW-1:0]   raddr,
  output logic [NRD-1:0][PW-1:0]   rmask,
  output logic [NRD-1:0][QW-1:0]   rqueue
);

  logic [PW-1:0] mask_mem [DEPTH];
  logic [QW-1:0] q_mem    [DEPTH];

  function automatic logic idx_ok(input logic [IW-1:0] a);
    return int'(a) < DEPTH;
  endfunction

  function automatic logic [PW-1:0] reset_mask(input int e);
    return (e == WL_IDX) ? (PW'(1) << CPU_POS) : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        mask_mem[e] <= reset_mask(e);
        q_mem[e]    <= '0;
      end
    end else if (we && idx_ok(waddr)) begin
      mask_mem[waddr] <= wmask;
      q_mem[waddr]    <= wqueue;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rmask[r]  = idx_ok(raddr[r]) ? mask_mem[raddr[r]] : '0;
    assign rqueue[r] = idx_ok(raddr[r]) ? q_mem[raddr[r]]    : '0;
  end

endmodule

// File: rtl/pgm_index_sel.sv
module pgm_index_sel
  import pgm_pkg::*;
#(
  parameter int NF       = 12,
  parameter int IW       = 7,
  parameter int SW       = 4,
  parameter int SRC_BASE = 80
) (
  input  logic          hit,
  input  logic [IW-1:0] dest_idx,
  input  logic [1:0]    fclass,
  input  logic [IW-1:0] f_uc,
  input  logic [IW-1:0] f_mc,
  input  logic [IW-1:0] f_bc,
  input  logic [SW-1:0] src,
  output logic [IW-1:0] dst_tbl_idx,
  output logic [IW-1:0] src_tbl_idx,
  output logic          src_ok
);

  function automatic logic [IW-1:0] pick_flood(input logic [1:0] c,
                                               input logic [IW-1:0] uc,
                                               input logic [IW-1:0] mc,
                                               input logic [IW-1:0] bc);
    case (flood_class_e'(c))
      FC_UCAST: return uc;
      FC_MCAST: return mc;
      default:  return bc;
    endcase
  endfunction

  assign src_ok      = int'(src) < NF;
  assign dst_tbl_idx = hit ? dest_idx : pick_flood(fclass, f_uc, f_mc, f_bc);
  assign src_tbl_idx = src_ok ? IW'(SRC_BASE + int'(src)) : '1;

endmodule

// File: rtl/pgm_combine.sv
module pgm_combine #(
  parameter int NF      = 12,
  parameter int PW      = 13,
  parameter int QW      = 3,
  parameter int SW      = 4,
  parameter int CPU_POS = 12
) (
  input  logic [PW-1:0] dmask,
  input  logic [QW-1:0] dqueue,
  input  logic [PW-1:0] smask,
  input  logic          hit,
  input  logic [1:0]    etype,
  input  logic [SW-1:0] src,
  output logic [PW-1:0] and_mask,
  output logic [PW-1:0] fwd_mask,
  output logic          cpu_copy,
  output logic [QW-1:0] cpu_queue
);

  localparam logic [PW-1:0] CPU_BIT = PW'(1) << CPU_POS;

  function automatic logic [PW-1:0] strip_ingress(input logic [PW-1:0] m,
                                                  input logic [SW-1:0] p);
    logic [PW-1:0] refl;
    refl = (int'(p) < NF) ? (PW'(1) << p) : '0;
    return m & ~refl;
  endfunction

  function automatic logic copy_rule(input logic h, input logic [1:0] t,
                                     input logic [PW-1:0] d);
    return h && (t == 2'd0 || t == 2'd1) && d[CPU_POS];
  endfunction

  assign and_mask  = dmask & smask;
  assign cpu_copy  = copy_rule(hit, etype, dmask);
  assign fwd_mask  = strip_ingress(and_mask, src) | (cpu_copy ? CPU_BIT : '0);
  assign cpu_queue = fwd_mask[CPU_POS] ? dqueue : '0;

endmodule

// File: rtl/pgm_resolver.sv
module pgm_resolver
  import pgm_pkg::*;
#(
  parameter int NF       = 12,
  parameter int CPU_POS  = 12,
  parameter int QW       = 3,
  parameter int IW       = 7,
  parameter int SRC_BASE = 80,
  parameter int WL_IDX   = 59,
  localparam int PW      = CPU_POS + 1,
  localparam int SW      = $clog2(NF + 1),
  localparam int DEPTH   = SRC_BASE + NF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [SW-1:0] req_src_port,
  input  logic          req_hit,
  input  logic [IW-1:0] req_dest_idx,
  input  logic [1:0]    req_entry_type,
  input  logic [1:0]    req_flood_class,
  input  logic [IW-1:0] flood_uc_idx,
  input  logic [IW-1:0] flood_mc_idx,
  input  logic [IW-1:0] flood_bc_idx,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_addr,
  input  logic [PW-1:0] cfg_wr_mask,
  input  logic [QW-1:0] cfg_wr_queue,
  output logic [PW-1:0] cfg_rd_mask,
  output logic [QW-1:0] cfg_rd_queue,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_mask,
  output logic          rsp_cpu_copy,
  output logic [QW-1:0] rsp_cpu_queue
);

  // stage 0: index selection and table read
  logic [IW-1:0] dst_tbl_idx, src_tbl_idx;
  logic          src_ok;
  logic [NUM_RD_PORTS-1:0][IW-1:0] rd_addr;
  logic [NUM_RD_PORTS-1:0][PW-1:0] rd_mask;
  logic [NUM_RD_PORTS-1:0][QW-1:0] rd_queue;

  pgm_index_sel #(.NF(NF), .IW(IW), .SW(SW), .SRC_BASE(SRC_BASE)) u_sel (
    .hit(req_hit), .dest_idx(req_dest_idx), .fclass(req_flood_class),
    .f_uc(flood_uc_idx), .f_mc(flood_mc_idx), .f_bc(flood_bc_idx),
    .src(req_src_port), .dst_tbl_idx(dst_tbl_idx),
    .src_tbl_idx(src_tbl_idx), .src_ok(src_ok)
  );

  always_comb begin
    rd_addr          = '0;
    rd_addr[RD_DEST] = dst_tbl_idx;
    rd_addr[RD_SRC]  = src_tbl_idx;
    rd_addr[RD_CFG]  = cfg_addr;
  end

  pgm_table #(.PW(PW), .QW(QW), .IW(IW), .DEPTH(DEPTH), .WL_IDX(WL_IDX),
              .CPU_POS(CPU_POS), .NRD(NUM_RD_PORTS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wmask(cfg_wr_mask), .wqueue(cfg_wr_queue),
    .raddr(rd_addr), .rmask(rd_mask), .rqueue(rd_queue)
  );

  // stage 1 registers
  logic          s1_valid, s1_hit;
  logic [1:0]    s1_etype;
  logic [SW-1:0] s1_src;
  logic [PW-1:0] s1_dmask, s1_smask;
  logic [QW-1:0] s1_dqueue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_hit    <= 1'b0;
      s1_etype  <= '0;
      s1_src    <= '0;
      s1_dmask  <= '0;
      s1_smask  <= '0;
      s1_dqueue <= '0;
    end else begin
      s1_valid  <= req_valid;
      s1_hit    <= req_hit;
      s1_etype  <= req_entry_type;
      s1_src    <= req_src_port;
      s1_dmask  <= rd_mask[RD_DEST];
      s1_smask  <= src_ok ? rd_mask[RD_SRC] : '0;
      s1_dqueue <= rd_queue[RD_DEST];
    end
  end

  // stage 1 combine
  logic [PW-1:0] and_mask, fwd_mask;
  logic          cpu_copy;
  logic [QW-1:0] cpu_queue;

  pgm_combine #(.NF(NF), .PW(PW), .QW(QW), .SW(SW), .CPU_POS(CPU_POS)) u_cmb (
    .dmask(s1_dmask), .dqueue(s1_dqueue), .smask(s1_smask),
    .hit(s1_hit), .etype(s1_etype), .src(s1_src),
    .and_mask(and_mask), .fwd_mask(fwd_mask),
    .cpu_copy(cpu_copy), .cpu_queue(cpu_queue)
  );

  // stage 2 registers (outputs)
  logic [SW-1:0] rsp_src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_mask      <= '0;
      rsp_cpu_copy  <= 1'b0;
      rsp_cpu_queue <= '0;
      rsp_src_q     <= '0;
    end else begin
      rsp_valid     <= s1_valid;
      rsp_mask      <= s1_valid ? fwd_mask  : '0;
      rsp_cpu_copy  <= s1_valid & cpu_copy;
      rsp_cpu_queue <= s1_valid ? cpu_queue : '0;
      rsp_src_q     <= s1_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rd_mask  <= '0;
      cfg_rd_queue <= '0;
    end else begin
      cfg_rd_mask  <= rd_mask[RD_CFG];
      cfg_rd_queue <= rd_queue[RD_CFG];
    end
  end

endmodule

// File: rtl/pgm_resolver_chk.sv
module pgm_resolver_chk #(
  parameter int NF      = 12,
  parameter int CPU_POS = 12,
  parameter int PW      = 13,
  parameter int QW      = 3,
  parameter int SW      = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          s1_valid,
  input logic          s1_hit,
  input logic          rsp_valid,
  input logic [PW-1:0] rsp_mask,
  input logic          rsp_cpu_copy,
  input logic [QW-1:0] rsp_cpu_queue,
  input logic [SW-1:0] rsp_src_q
);

  // R6
  req_to_s1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> s1_valid);

  // R6
  s1_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> rsp_valid);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_mask == '0 && !rsp_cpu_copy && rsp_cpu_queue == '0));

  // R1
  no_reflect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && int'(rsp_src_q) < NF) |-> !rsp_mask[rsp_src_q]);

  // R3
  copy_sets_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cpu_copy |-> rsp_mask[CPU_POS]);

  // R4
  flood_no_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_hit) |=> !rsp_cpu_copy);

  // R5
  queue_needs_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_mask[CPU_POS] |-> rsp_cpu_queue == '0);

endmodule

bind pgm_resolver pgm_resolver_chk #(
  .NF(NF), .CPU_POS(CPU_POS), .PW(PW), .QW(QW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .s1_valid(s1_valid), .s1_hit(s1_hit),
  .rsp_valid(rsp_valid), .rsp_mask(rsp_mask),
  .rsp_cpu_copy(rsp_cpu_copy), .rsp_cpu_queue(rsp_cpu_queue),
  .rsp_src_q(rsp_src_q)
);

// File: tb/pgm_resolver_test.sv
module pgm_resolver_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_src_port = '0;
  logic        req_hit = 1'b0;
  logic [6:0]  req_dest_idx = '0;
  logic [1:0]  req_entry_type = '0;
  logic [1:0]  req_flood_class = '0;
  logic [6:0]  flood_uc_idx = 7'd60;
  logic [6:0]  flood_mc_idx = 7'd61;
  logic [6:0]  flood_bc_idx = 7'd62;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = 7'd59;
  logic [12:0] cfg_wr_mask = '0;
  logic [2:0]  cfg_wr_queue = '0;
  logic [12:0] cfg_rd_mask;
  logic [2:0]  cfg_rd_queue;
  logic        rsp_valid;
  logic [12:0] rsp_mask;
  logic        rsp_cpu_copy;
  logic [2:0]  rsp_cpu_queue;

  pgm_resolver uut (.*);

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_tag  = "R7";
  bit    done     = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int tm[128];
  int tq[128];
  int e1v, e1m, e1c, e1q, e2v, e2m, e2c, e2q;
  int cexp_m, cexp_q;

  task automatic model_reset();
    for (int i = 0; i < 128; i++) begin
      tm[i] = 0;
      tq[i] = 0;
    end
    tm[59] = 1 << 12;
    e1v = 0; e1m = 0; e1c = 0; e1q = 0;
    e2v = 0; e2m = 0; e2c = 0; e2q = 0;
    cexp_m = 0; cexp_q = 0;
  endtask

  function automatic int rd_m(input int i);
    return (i < 92) ? tm[i] : 0;
  endfunction
  function automatic int rd_q(input int i);
    return (i < 92) ? tq[i] : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int di, dm, dq, sm, m, cp, src;
      e2v = e1v; e2m = e1m; e2c = e1c; e2q = e1q;
      if (req_valid) begin
        src = int'(req_src_port);
        if (req_hit) di = int'(req_dest_idx);
        else if (req_flood_class == 2'd0) di = int'(flood_uc_idx);
        else if (req_flood_class == 2'd1) di = int'(flood_mc_idx);
        else di = int'(flood_bc_idx);
        dm = rd_m(di);
        dq = rd_q(di);
        sm = (src < 12) ? rd_m(80 + src) : 0;
        m = 0;
        for (int j = 0; j < 13; j++)
          if (((dm >> j) & 1) == 1 && ((sm >> j) & 1) == 1 && j != src) m += (1 << j);
        cp = (req_hit && req_entry_type < 2 && ((dm >> 12) & 1) == 1) ? 1 : 0;
        if (cp == 1) m = m | (1 << 12);
        e1v = 1; e1m = m; e1c = cp; e1q = (((m >> 12) & 1) == 1) ? dq : 0;
      end else begin
        e1v = 0; e1m = 0; e1c = 0; e1q = 0;
      end
      cexp_m = rd_m(int'(cfg_addr));
      cexp_q = rd_q(int'(cfg_addr));
      if (cfg_we && cfg_addr < 7'd92) begin
        tm[cfg_addr] = int'(cfg_wr_mask);
        tq[cfg_addr] = int'(cfg_wr_queue);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        // R7: outputs held at zero during reset
        chk("R7", "reset rsp_valid", int'(rsp_valid), 0);
        chk("R7", "reset cfg_rd_mask", int'(cfg_rd_mask), 0);
      end else begin
        chk(cur_tag, "rsp_valid", int'(rsp_valid), e2v);
        chk(cur_tag, "rsp_mask", int'(rsp_mask), e2m);
        chk(cur_tag, "rsp_cpu_copy", int'(rsp_cpu_copy), e2c);
        chk(cur_tag, "rsp_cpu_queue", int'(rsp_cpu_queue), e2q);
        chk("R8", "cfg_rd_mask", int'(cfg_rd_mask), cexp_m);
        chk("R8", "cfg_rd_queue", int'(cfg_rd_queue), cexp_q);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      cfg_we = 1'b0;
    end
  endtask

  task automatic wr(input int idx, input int m, input int q);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_addr = 7'(idx);
    cfg_wr_mask = 13'(m);
    cfg_wr_queue = 3'(q);
  endtask

  task automatic req(input int src, input bit hit, input int idx, input int et, input int cls);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b1;
    req_src_port = 4'(src);
    req_hit = hit;
    req_dest_idx = 7'(idx);
    req_entry_type = 2'(et);
    req_flood_class = 2'(cls);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: whitelist entry holds only the CPU bit, others zero
    cur_tag = "R7";
    idle(2);
    @(negedge clk); cfg_addr = 7'd0;
    @(negedge clk); cfg_addr = 7'd91;
    idle(2);

    // R8: configure the table
    cur_tag = "R8";
    for (int i = 0; i < 12; i++) wr(i, 1 << i, 0);
    for (int i = 0; i < 12; i++) wr(80 + i, (i == 3) ? 13'h1FFF : 13'h0FFF, 0);
    wr(40, 13'h1026, 5);
    wr(59, 13'h1000, 6);
    wr(60, 13'h1FFF, 2);
    wr(61, 13'h00F0, 1);
    wr(62, 13'h1FFF, 7);
    // R8: write and read of the same entry in one cycle gives the old value
    wr(40, 13'h1026, 5);
    wr(41, 13'h0003, 4);
    wr(41, 13'h0005, 3);
    idle(2);

    // R1: AND and ingress removal
    cur_tag = "R1";
    req(0, 1, 5, 0, 0);
    req(5, 1, 5, 0, 0);
    req(1, 1, 40, 2, 0);
    req(2, 1, 41, 0, 0);
    idle(3);

    // R2: hit index versus flood class mapping
    cur_tag = "R2";
    req(1, 0, 0, 0, 0);
    req(1, 0, 0, 0, 1);
    req(1, 0, 0, 0, 2);
    req(1, 0, 0, 0, 3);
    req(4, 1, 61, 3, 2);
    idle(3);

    // R3: copy exception overrides a source entry without the CPU bit
    cur_tag = "R3";
    req(0, 1, 59, 0, 0);
    req(0, 1, 59, 1, 0);
    req(0, 1, 59, 2, 0);
    req(0, 1, 59, 3, 0);
    req(1, 1, 40, 0, 0);
    idle(3);

    // R4: floods only reach the CPU through the AND
    cur_tag = "R4";
    req(0, 0, 59, 0, 2);
    req(3, 0, 59, 0, 2);
    req(3, 0, 59, 0, 1);
    idle(3);

    // R5: queue taken from the destination entry
    cur_tag = "R5";
    req(3, 0, 0, 0, 0);
    req(3, 1, 40, 2, 0);
    req(6, 1, 40, 1, 0);
    idle(3);

    // R6: back-to-back requests with gaps
    cur_tag = "R6";
    for (int k = 0; k < 12; k++) req(k, 1, (k + 3) % 12, 0, 0);
    idle(1);
    req(2, 1, 7, 0, 0);
    idle(3);

    // R9: out-of-range ports and indices
    cur_tag = "R9";
    wr(120, 13'h1FFF, 7);
    @(negedge clk); cfg_we = 1'b0; cfg_addr = 7'd120;
    req(13, 1, 7, 0, 0);
    req(0, 1, 100, 0, 0);
    req(15, 0, 0, 0, 2);
    idle(3);

    // random mixed traffic and writes (R1 main function)
    cur_tag = "R1";
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      req_valid = ($urandom_range(0, 3) != 0);
      req_src_port = 4'($urandom_range(0, 13));
      req_hit = $urandom_range(0, 1) == 1;
      req_dest_idx = ($urandom_range(0, 7) == 0) ? 7'(59) : 7'($urandom_range(0, 95));
      req_entry_type = 2'($urandom_range(0, 3));
      req_flood_class = 2'($urandom_range(0, 3));
      cfg_we = ($urandom_range(0, 4) == 0);
      cfg_addr = 7'($urandom_range(0, 95));
      cfg_wr_mask = 13'($urandom_range(0, 8191));
      cfg_wr_queue = 3'($urandom_range(0, 7));
    end
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule